// File: doc/BRIEF.md
# Halfword Write DMA Sequencer for a Parallel Display Bus

This block moves a block of 32-bit words from memory to a parallel display or microprocessor-style bus controller. Each word becomes two 16-bit write transactions. Software programs a start address, an end address and a chip-select choice, then raises an enable bit. The block then reads words one at a time through a request/grant/return memory port. It hands every halfword to the bus timing engine, which is modelled here as a valid/ready write sink. When the last halfword of the end word has been taken, it pulses `done`.

The sequencer only ever writes outward. It never reads the panel. While the enable bit is high it refuses CPU accesses to the index and data registers, so that software cannot interleave its own bus traffic with the run. The second chip select carries writes only when the bus mode selects an asynchronous protocol. Otherwise each halfword for that chip select is discarded and tallied in a wrapping reject counter.

Top module: `hw_dma_seq`

## Requirements
- R1: A run begins only on a low-to-high change of `cfg_en`. Keeping `cfg_en` high after a run has ended issues no further fetch.
- R2: The fetch addresses are `cfg_base`, `cfg_base`+4, and so on up to and including `cfg_ceil`, in ascending order.
- R3: If either address has a nonzero value in bits 1:0, or if `cfg_ceil` is below `cfg_base`, a rising `cfg_en` gives a one-cycle `cfg_err` pulse. No fetch is made and `busy` stays low.
- R4: Every fetched word yields exactly two halfword writes, so N words give 2N handshakes. `bus_data` stays unchanged while `bus_valid` is high and `bus_ready` is low.
- R5: For each word, the halfword in bits 15:0 is written first and the halfword in bits 31:16 second.
- R6: `bus_cs1` equals `cfg_cs1` for every write of a run (0 selects chip select 0, 1 selects chip select 1).
- R7: The values 4 to 7 of `cfg_mode` are asynchronous modes and 0 to 3 are synchronous. With `cfg_cs1`=1 and a synchronous mode, no halfword is presented (`bus_valid` stays low). Instead `rej_cnt` rises by one per dropped halfword and wraps modulo 2^CW. The run still finishes with `done`. Chip select 0 writes do not depend on the mode.
- R8: At most one memory read is outstanding. After a grant, `mem_req` stays low until both halves of that word have been accepted or dropped.
- R9: `cpu_ok` is high when `cpu_req` is high and `cfg_en` is low. `cpu_nak` is high when `cpu_req` and `cfg_en` are both high.
- R10: `done` is a one-cycle pulse in the cycle after the last halfword of the `cfg_ceil` word completes. `busy` is low in that cycle.
- R11: If `cfg_en` falls during a run, the halfword in flight is completed. After that, no further write or fetch is made, `done` is not raised and the block returns to idle.
- R12: During and directly after reset, `mem_req`, `bus_valid`, `done`, `cfg_err` and `busy` are low and `rej_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | DMA enable; a rising edge starts a run |
| cfg_base | input | AW | Byte address of the first word |
| cfg_ceil | input | AW | Byte address of the last word |
| cfg_cs1 | input | 1 | Target chip select: 0 or 1 |
| cfg_mode | input | 3 | Bus mode; 4 to 7 are asynchronous |
| cpu_req | input | 1 | CPU access to index/data registers |
| cpu_ok | output | 1 | CPU access allowed |
| cpu_nak | output | 1 | CPU access refused |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_gnt | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 2*HW | Read data word |
| bus_valid | output | 1 | Halfword write valid |
| bus_ready | input | 1 | Bus engine takes the write |
| bus_data | output | HW | Halfword write data |
| bus_cs1 | output | 1 | Chip select of the write |
| rej_cnt | output | CW | Count of dropped chip select 1 halfwords |
| done | output | 1 | Run-complete pulse |
| cfg_err | output | 1 | Bad-address pulse |
| busy | output | 1 | Run in progress |

## Verification
The bench builds the block with AW=12, HW=16 and CW=4. The narrow address keeps every run within a small memory model. The four-bit reject counter wraps after sixteen drops, and the two synchronous chip select 1 runs drop 26 halfwords in total, so the modulo behaviour is exercised. Alternating grant and ready patterns make the request hold, the data hold and the single-outstanding-read rule visible across stall cycles.

// File: rtl/hw_dma_pkg.sv
package hw_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_LO,
    ST_HI
  } seq_st_e;

  localparam int unsigned WORD_BYTES = 4;

  // modes with the top bit set drive an asynchronous protocol
  function automatic logic mode_is_async(input logic [2:0] m);
    return m[2];
  endfunction

endpackage

// File: rtl/hw_dma_ctrl.sv
module hw_dma_ctrl
  import hw_dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned HW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   ceil,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [2*HW-1:0] mem_rdata,
  input  logic            lane_adv,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [2*HW-1:0] word,
  output logic            hi_sel,
  output logic            lane_act,
  output logic            done,
  output logic            cfg_err,
  output logic            busy
);

  localparam int unsigned WW = 2 * HW;

  seq_st_e        st_q, st_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           addr_en;
  logic [WW-1:0]  word_q;
  logic           word_en;
  logic           en_q;
  logic           done_q, done_d;
  logic           err_q, err_d;
  logic           bad_cfg;

  assign bad_cfg = (|base[1:0]) | (|ceil[1:0]) | (ceil < base);

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en && !en_q) begin
          if (bad_cfg) begin
            err_d = 1'b1;
          end else begin
            addr_d  = base;
            addr_en = 1'b1;
            st_d    = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_gnt)  st_d = ST_WAIT;
        else if (!en) st_d = ST_IDLE;
      end
      ST_WAIT: begin
        if (mem_rvalid) st_d = en ? ST_LO : ST_IDLE;
      end
      ST_LO: begin
        if (lane_adv) st_d = en ? ST_HI : ST_IDLE;
      end
      ST_HI: begin
        if (lane_adv) begin
          if (!en) begin
            st_d = ST_IDLE;
          end else if (addr_q == ceil) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            addr_d  = addr_q + AW'(WORD_BYTES);
            addr_en = 1'b1;
            st_d    = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign word_en = (st_q == ST_WAIT) && mem_rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      en_q   <= en;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= mem_rdata;
  end

  assign mem_req  = (st_q == ST_REQ);
  assign mem_addr = addr_q;
  assign word     = word_q;
  assign hi_sel   = (st_q == ST_HI);
  assign lane_act = (st_q == ST_LO) || (st_q == ST_HI);
  assign done     = done_q;
  assign cfg_err  = err_q;
  assign busy     = (st_q != ST_IDLE);

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req) else $error("second read while one outstanding"); // R8
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= base) && (mem_addr <= ceil)) else $error("fetch outside window"); // R2
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !mem_req) else $error("run started on bad config"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10

endmodule

// File: rtl/hw_dma_lane.sv
module hw_dma_lane
  import hw_dma_pkg::*;
#(
  parameter int unsigned HW = 16,
  parameter int unsigned CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*HW-1:0] word,
  input  logic            hi_sel,
  input  logic            active,
  input  logic            cs1,
  input  logic [2:0]      mode,
  input  logic            bus_ready,
  output logic            bus_valid,
  output logic [HW-1:0]   bus_data,
  output logic            bus_cs1,
  output logic            adv,
  output logic [CW-1:0]   rej_cnt
);

  logic          drop;
  logic [CW-1:0] rej_q;

  assign drop      = active && cs1 && !mode_is_async(mode);
  assign bus_valid = active && !drop;
  assign bus_data  = hi_sel ? word[2*HW-1:HW] : word[HW-1:0];
  assign bus_cs1   = cs1;
  assign adv       = drop || (bus_valid && bus_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rej_q <= '0;
    else if (drop) rej_q <= rej_q + CW'(1);
  end

  assign rej_cnt = rej_q;

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_data)) else $error("write changed while stalled"); // R4
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> $stable(bus_cs1)) else $error("chip select moved in run"); // R6
  AST_SYNC_CS1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cs1) |-> mode[2]) else $error("cs1 write in synchronous mode"); // R7

endmodule

// File: rtl/hw_dma_seq.sv
module hw_dma_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned HW = 16,
  parameter int unsigned CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_ceil,
  input  logic            cfg_cs1,
  input  logic [2:0]      cfg_mode,
  input  logic            cpu_req,
  output logic            cpu_ok,
  output logic            cpu_nak,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [2*HW-1:0] mem_rdata,
  output logic            bus_valid,
  input  logic            bus_ready,
  output logic [HW-1:0]   bus_data,
  output logic            bus_cs1,
  output logic [CW-1:0]   rej_cnt,
  output logic            done,
  output logic            cfg_err,
  output logic            busy
);

  localparam int unsigned WW = 2 * HW;

  logic [1:0]    rst_pipe;
  logic          rst_n_i;
  logic [WW-1:0] word;
  logic          hi_sel;
  logic          lane_act;
  logic          lane_adv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  assign cpu_ok  = cpu_req && !cfg_en;
  assign cpu_nak = cpu_req && cfg_en;

  hw_dma_ctrl #(.AW(AW), .HW(HW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .en         (cfg_en),
    .base       (cfg_base),
    .ceil       (cfg_ceil),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .lane_adv   (lane_adv),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .word       (word),
    .hi_sel     (hi_sel),
    .lane_act   (lane_act),
    .done       (done),
    .cfg_err    (cfg_err),
    .busy       (busy)
  );

  hw_dma_lane #(.HW(HW), .CW(CW)) lane_i (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .word      (word),
    .hi_sel    (hi_sel),
    .active    (lane_act),
    .cs1       (cfg_cs1),
    .mode      (cfg_mode),
    .bus_ready (bus_ready),
    .bus_valid (bus_valid),
    .bus_data  (bus_data),
    .bus_cs1   (bus_cs1),
    .adv       (lane_adv),
    .rej_cnt   (rej_cnt)
  );

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_req && cfg_en) |-> cpu_nak && !cpu_ok) else $error("cpu access during dma"); // R9
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_valid |-> busy) else $error("write outside a run"); // R11

endmodule

// File: tb/hw_dma_seq_tb.sv
`timescale 1ns/1ps
module hw_dma_seq_tb_top;

  localparam int unsigned AW = 12;
  localparam int unsigned HW = 16;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_ceil = '0;
  logic          cfg_cs1 = 1'b0;
  logic [2:0]    cfg_mode = '0;
  logic          cpu_req = 1'b0;
  logic          cpu_ok, cpu_nak;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_gnt = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic [HW-1:0] bus_data;
  logic          bus_cs1;
  logic [CW-1:0] rej_cnt;
  logic          done, cfg_err, busy;

  always #2.5 clk = ~clk;

  hw_dma_seq #(.AW(AW), .HW(HW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_ceil(cfg_ceil),
    .cfg_cs1(cfg_cs1), .cfg_mode(cfg_mode), .cpu_req(cpu_req), .cpu_ok(cpu_ok), .cpu_nak(cpu_nak),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_data(bus_data),
    .bus_cs1(bus_cs1), .rej_cnt(rej_cnt), .done(done), .cfg_err(cfg_err), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // observation state filled by the responder
  logic [HW-1:0] rec_data [64];
  logic          rec_cs   [64];
  logic [AW-1:0] fetch_log [32];
  int rec_cnt = 0, fetch_cnt = 0, done_cnt = 0, err_cnt = 0;
  bit rdy_alt = 1'b0, gnt_alt = 1'b0;
  bit pend = 1'b0;
  logic [AW-1:0] paddr = '0;

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    return {4'hC, ~a, 4'h3, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and bus sink, driven between clock edges
  initial begin
    forever begin
      @(negedge clk);
      mem_gnt   = gnt_alt ? ~mem_gnt : 1'b1;
      bus_ready = rdy_alt ? ~bus_ready : 1'b1;
      mem_rvalid = 1'b0;
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(paddr);
        pend = 1'b0;
      end
      if (mem_req && mem_gnt) begin
        pend  = 1'b1;
        paddr = mem_addr;
        if (fetch_cnt < 32) fetch_log[fetch_cnt] = mem_addr;
        fetch_cnt++;
      end
      if (bus_valid && bus_ready) begin
        if (rec_cnt < 64) begin
          rec_data[rec_cnt] = bus_data;
          rec_cs[rec_cnt]   = bus_cs1;
        end
        rec_cnt++;
      end
      if (done)    done_cnt++;
      if (cfg_err) err_cnt++;
    end
  end

  // {base, ceil, cs1, mode, ready alternating, grant alternating, error expected}
  localparam logic [30:0] VEC [9] = '{
    {12'h100, 12'h108, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {12'h200, 12'h200, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0},
    {12'h300, 12'h30C, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
    {12'h402, 12'h40C, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1},
    {12'h400, 12'h40D, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1},
    {12'h500, 12'h4FC, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1},
    {12'h040, 12'h060, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
    {12'h600, 12'h620, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0},
    {12'h0FC, 12'h100, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0}
  };

  logic [CW-1:0] rej_exp = '0;

  task automatic clear_obs();
    rec_cnt = 0; fetch_cnt = 0; done_cnt = 0; err_cnt = 0;
  endtask

  task automatic run_vec(input logic [30:0] v);
    logic [AW-1:0] b, c;
    bit cs, ee, drop;
    int nw, exp_wr, snap;
    logic [31:0] w;
    logic [HW-1:0] eh;
    b = v[30:19]; c = v[18:7]; cs = v[6]; ee = v[0];
    @(posedge clk); #1;
    cfg_base = b; cfg_ceil = c; cfg_cs1 = cs; cfg_mode = v[5:3];
    rdy_alt = v[2]; gnt_alt = v[1];
    clear_obs();
    nw = ee ? 0 : int'((c - b) / 4) + 1;
    drop = cs && !v[5];
    exp_wr = drop ? 0 : 2 * nw;
    cfg_en = 1'b1;
    for (int k = 0; k < 3000 && done_cnt == 0 && err_cnt == 0; k++) begin
      @(posedge clk); #1;
    end
    chk(err_cnt == (ee ? 1 : 0), "R3 error pulse", err_cnt, ee ? 1 : 0);
    chk(done_cnt == (ee ? 0 : 1), "R10 done pulse", done_cnt, ee ? 0 : 1);
    chk(busy == 1'b0, "R10 idle after end", busy, 0);
    snap = fetch_cnt;
    repeat (10) begin @(posedge clk); #1; end
    chk(fetch_cnt == snap, "R1 no restart while enable held", fetch_cnt, snap);
    chk(fetch_cnt == nw, "R2 fetch count", fetch_cnt, nw);
    for (int i = 0; i < nw && i < 32; i++)
      chk(fetch_log[i] == b + AW'(4 * i), "R2 fetch address", fetch_log[i], b + AW'(4 * i));
    chk(rec_cnt == exp_wr, "R4 write count", rec_cnt, exp_wr);
    for (int i = 0; i < exp_wr && i < 64; i++) begin
      w  = mem_word(b + AW'(4 * (i / 2)));
      eh = (i % 2 == 1) ? w[31:16] : w[15:0];
      chk(rec_data[i] == eh, "R5 halfword order and data", rec_data[i], eh);
      chk(rec_cs[i] == cs, "R6 chip select", rec_cs[i], cs);
    end
    if (drop) rej_exp = rej_exp + CW'(2 * nw);
    chk(rej_cnt == rej_exp, "R7 reject count", rej_cnt, rej_exp);
    cfg_en = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(posedge clk);
    #1;
    chk({mem_req, bus_valid, done, cfg_err, busy} == 5'b0, "R12 outputs in reset",
        {mem_req, bus_valid, done, cfg_err, busy}, 0);
    rst_n = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    chk({mem_req, bus_valid, done, cfg_err, busy} == 5'b0, "R12 outputs after reset",
        {mem_req, bus_valid, done, cfg_err, busy}, 0);
    chk(rej_cnt == '0, "R12 reject count", rej_cnt, 0);

    for (int n = 0; n < 9; n++) run_vec(VEC[n]);

    // R9 lockout with enable low, then high on a rejected config
    cpu_req = 1'b1; #1;
    chk(cpu_ok && !cpu_nak, "R9 access allowed when idle", {cpu_ok, cpu_nak}, 2'b10);
    cfg_base = 12'h001; cfg_ceil = 12'h010; cfg_en = 1'b1; #1;
    chk(!cpu_ok && cpu_nak, "R9 access refused while enabled", {cpu_ok, cpu_nak}, 2'b01);
    cfg_en = 1'b0; cpu_req = 1'b0;
    repeat (3) begin @(posedge clk); #1; end

    // R11 abort after the first halfword
    cfg_base = 12'h700; cfg_ceil = 12'h73C; cfg_cs1 = 1'b0; cfg_mode = 3'd0;
    rdy_alt = 1'b0; gnt_alt = 1'b0;
    clear_obs();
    cfg_en = 1'b1;
    for (int k = 0; k < 200 && rec_cnt == 0; k++) @(negedge clk);
    cfg_en = 1'b0;
    repeat (20) begin @(posedge clk); #1; end
    chk(rec_cnt == 1, "R11 only in-flight halfword written", rec_cnt, 1);
    chk(fetch_cnt == 1, "R11 no fetch after abort", fetch_cnt, 1);
    chk(done_cnt == 0, "R11 no done on abort", done_cnt, 0);
    chk(busy == 1'b0, "R11 back to idle", busy, 0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule